// File: doc/BRIEF.md
# Converter Control Word and Power-Mode Controller

This block holds the configuration of a dual-channel digital-to-analog converter. Software or a host device writes an 8-bit control word over the channel A data lines and marks it with an active-low write strobe. The word is taken on the strobe's rising edge. The strobe has no fixed relation to the conversion clock, and the conversion clock may keep running while a write takes place.

The captured word is moved into the conversion-clock domain through a toggle flag and a synchronizer chain. The word is then split into its fields: power-down, converter enable, interleaved input, external reference select and a 4-bit gain trim. The power-down and enable bits drive a three-state mode machine with the states run, standby and off. When the machine returns to run from a low-power state, a ready output stays low for a wake-up interval counted in conversion-clock cycles. That interval is longer if power-down was visited. The gain trim is also given as a signed count of 0.05 dB steps.

Top module: `cw_mode_ctrl`

## Requirements
- R1: The word is taken from `cw_data` at the rising edge of `wr_n`. A value placed on `cw_data` after that edge has no effect on the outputs.
- R2: After reset the outputs are:
  - `mode_o` = 2'b00 (run)
  - `ready_o` = 1
  - `intlv_o` = 0
  - `ext_ref_o` = 0
  - `gain_code_o` = 4'b1000
  - `gain_step_o` = 0
- R3: Word bit 5 appears on `intlv_o`, bit 4 on `ext_ref_o` (1 selects the external reference) and bits 3..0 on `gain_code_o`.
- R4: Word bit 7 = 1 selects `mode_o` = 2'b10 (off), whatever the other bits hold.
- R5: With bit 7 = 0, bit 6 = 0 selects `mode_o` = 2'b01 (standby) and bit 6 = 1 selects 2'b00 (run).
- R6: `gain_step_o` is a 5-bit two's-complement value equal to 8 minus `gain_code_o`. Code 0000 gives +8, code 1000 gives 0 and code 1111 gives -7.
- R7: `ready_o` is 0 in every cycle in which `mode_o` is not run.
- R8: After a return from standby to run, `ready_o` rises exactly CLK_MHZ*STBY_US cycles after `mode_o` first shows run.
- R9: After a return to run, if the off mode was entered since `ready_o` was last high, `ready_o` rises CLK_MHZ*PDN_US cycles after `mode_o` first shows run. This holds even when the return passes through standby.
- R10: A write that leaves the mode at run updates the fields by the fourth rising clock edge after the strobe rises. If `ready_o` is high, it stays high through that write.
- R11: A write that keeps the mode at run during a wake-up interval neither restarts nor lengthens that interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Active-high reset, synchronous in the clock domain, asynchronous on the strobe side |
| wr_n | input | 1 | Active-low write strobe; word captured on its rising edge |
| cw_data | input | 8 | Shared channel A data lines carrying the control word |
| mode_o | output | 2 | Power mode: 00 run, 01 standby, 10 off |
| ready_o | output | 1 | Converter outputs valid |
| intlv_o | output | 1 | Interleaved input enabled |
| ext_ref_o | output | 1 | External reference selected |
| gain_code_o | output | 4 | Raw gain trim code |
| gain_step_o | output | 5 | Signed gain trim in 0.05 dB steps |

## Verification
Several properties are checked on every cycle:
- the synchronized word changes only on an update pulse;
- the fields follow that word one cycle later;
- a set power-down bit forces the off mode;
- ready is never high outside run;
- each return to run begins with ready low.

Some behaviours can only be shown by the bench's scenarios:
- the exact wake-up counts for standby and for power-down, including the path through standby;
- the fact that data changed after the strobe edge is ignored;
- a gain write during a wake-up neither restarts it nor lowers a high ready.

// File: rtl/cwm_pkg.sv
package cwm_pkg;
  localparam int CW_W    = 8;
  localparam int PD_BIT  = 7;
  localparam int EN_BIT  = 6;
  localparam int IL_BIT  = 5;
  localparam int REF_BIT = 4;
  localparam int GAIN_W  = 4;
  localparam int STEP_W  = GAIN_W + 1;
  localparam int GAIN_MID = 1 << (GAIN_W - 1);
  // power-up word: run mode, internal reference, non-interleaved, 0 dB trim
  localparam logic [CW_W-1:0] CW_DEFAULT = 8'h48;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_STBY = 2'b01,
    MODE_OFF  = 2'b10
  } pmode_e;
endpackage

// File: rtl/cwm_capture.sv
module cwm_capture
  import cwm_pkg::*;
(
  input  logic            rst,
  input  logic            wr_n,
  input  logic [CW_W-1:0] data_i,
  output logic [CW_W-1:0] word_a,
  output logic            tog_a
);
  // strobe-domain register: the strobe is its clock, so reset has to be asynchronous here
  always_ff @(posedge wr_n or posedge rst) begin
    if (rst) begin
      word_a <= CW_DEFAULT;
      tog_a  <= 1'b0;
    end else begin
      word_a <= data_i;
      tog_a  <= ~tog_a;
    end
  end
endmodule

// File: rtl/cwm_sync.sv
module cwm_sync
  import cwm_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tog_a,
  input  logic [CW_W-1:0] word_a,
  output logic [CW_W-1:0] word_q,
  output logic            upd_o
);
  // chain[0..STAGES-1] synchronize, chain[STAGES] remembers the previous level
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], tog_a};
  end

  assign upd_o = chain[STAGES] ^ chain[STAGES-1];

  // word_a has been stable for STAGES cycles once the toggle is seen
  always_ff @(posedge clk) begin
    if (rst)        word_q <= CW_DEFAULT;
    else if (upd_o) word_q <= word_a;
  end

  // R1: the clock-domain copy moves only on an update pulse
  assert_word_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !upd_o |=> (word_q == $past(word_q)));
endmodule

// File: rtl/cwm_decode.sv
module cwm_decode
  import cwm_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CW_W-1:0]          word_q,
  output logic                     pd_o,
  output logic                     en_o,
  output logic                     intlv_o,
  output logic                     ext_ref_o,
  output logic [GAIN_W-1:0]        gain_code_o,
  output logic signed [STEP_W-1:0] gain_step_o
);
  assign pd_o = word_q[PD_BIT];
  assign en_o = word_q[EN_BIT];

  logic signed [STEP_W-1:0] step_d;
  assign step_d = STEP_W'(GAIN_MID) - $signed({1'b0, word_q[GAIN_W-1:0]});

  always_ff @(posedge clk) begin
    if (rst) begin
      intlv_o     <= CW_DEFAULT[IL_BIT];
      ext_ref_o   <= CW_DEFAULT[REF_BIT];
      gain_code_o <= CW_DEFAULT[GAIN_W-1:0];
      gain_step_o <= '0;
    end else begin
      intlv_o     <= word_q[IL_BIT];
      ext_ref_o   <= word_q[REF_BIT];
      gain_code_o <= word_q[GAIN_W-1:0];
      gain_step_o <= step_d;
    end
  end

  // R3: the fields track the synchronized word one cycle later
  assert_field_follow_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (gain_code_o == $past(word_q[GAIN_W-1:0])) &&
             (intlv_o == $past(word_q[IL_BIT])) &&
             (ext_ref_o == $past(word_q[REF_BIT])));
endmodule

// File: rtl/cwm_fsm.sv
module cwm_fsm
  import cwm_pkg::*;
#(
  parameter int STBY_CYC = 300,
  parameter int PDN_CYC  = 50000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pd_i,
  input  logic       en_i,
  output logic [1:0] mode_o,
  output logic       ready_o
);
  localparam int MAX_CYC = (PDN_CYC > STBY_CYC) ? PDN_CYC : STBY_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] STBY_LOAD = CNT_W'(STBY_CYC - 1);
  localparam logic [CNT_W-1:0] PDN_LOAD  = CNT_W'(PDN_CYC - 1);

  pmode_e           state, target;
  logic [CNT_W-1:0] cnt;
  logic             cold;   // off mode visited since the last valid output

  always_comb begin
    if (pd_i)      target = MODE_OFF;
    else if (en_i) target = MODE_RUN;
    else           target = MODE_STBY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= MODE_RUN;
      cnt     <= '0;
      ready_o <= 1'b1;
      cold    <= 1'b0;
    end else if (target != MODE_RUN) begin
      state   <= target;
      cnt     <= '0;
      ready_o <= 1'b0;
      if (target == MODE_OFF) cold <= 1'b1;
    end else if (state != MODE_RUN) begin
      state   <= MODE_RUN;
      cnt     <= cold ? PDN_LOAD : STBY_LOAD;
      ready_o <= 1'b0;
    end else if (!ready_o) begin
      if (cnt == '0) begin
        ready_o <= 1'b1;
        cold    <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign mode_o = state;

  // R4: a set power-down bit always lands in the off mode
  assert_pd_priority_R4: assert property (@(posedge clk) disable iff (rst)
    pd_i |=> (state == MODE_OFF));

  // R7: no valid output outside run
  assert_ready_only_run_R7: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (state == MODE_RUN));

  // R8: every return to run starts with ready low
  assert_wake_starts_low_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(state) != MODE_RUN) && (state == MODE_RUN) |-> !ready_o);
endmodule

// File: rtl/cw_mode_ctrl.sv
module cw_mode_ctrl
  import cwm_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int STBY_US     = 3,
  parameter int PDN_US      = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_n,
  input  logic [7:0]        cw_data,
  output logic [1:0]        mode_o,
  output logic              ready_o,
  output logic              intlv_o,
  output logic              ext_ref_o,
  output logic [3:0]        gain_code_o,
  output logic signed [4:0] gain_step_o
);
  localparam int STBY_CYC = CLK_MHZ * STBY_US;
  localparam int PDN_CYC  = CLK_MHZ * PDN_US;

  logic [CW_W-1:0] word_a, word_q;
  logic            tog_a, upd, pd, en;

  cwm_capture u_cap (
    .rst(rst), .wr_n(wr_n), .data_i(cw_data),
    .word_a(word_a), .tog_a(tog_a)
  );

  cwm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .tog_a(tog_a), .word_a(word_a),
    .word_q(word_q), .upd_o(upd)
  );

  cwm_decode u_dec (
    .clk(clk), .rst(rst), .word_q(word_q),
    .pd_o(pd), .en_o(en),
    .intlv_o(intlv_o), .ext_ref_o(ext_ref_o),
    .gain_code_o(gain_code_o), .gain_step_o(gain_step_o)
  );

  cwm_fsm #(.STBY_CYC(STBY_CYC), .PDN_CYC(PDN_CYC)) u_fsm (
    .clk(clk), .rst(rst), .pd_i(pd), .en_i(en),
    .mode_o(mode_o), .ready_o(ready_o)
  );
endmodule

// File: tb/cw_mode_ctrl_tb.sv
module cw_mode_ctrl_tb;
  localparam int STBY_N = 300;    // 100 MHz * 3 us
  localparam int PDN_N  = 50000;  // 100 MHz * 500 us

  logic clk = 1'b0, rst = 1'b1, wr_n = 1'b1;
  logic [7:0] cw_data = 8'h00;
  logic [1:0] mode_o;
  logic ready_o, intlv_o, ext_ref_o;
  logic [3:0] gain_code_o;
  logic signed [4:0] gain_step_o;

  always #5 clk = ~clk;

  cw_mode_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_n(wr_n), .cw_data(cw_data),
    .mode_o(mode_o), .ready_o(ready_o), .intlv_o(intlv_o),
    .ext_ref_o(ext_ref_o), .gain_code_o(gain_code_o), .gain_step_o(gain_step_o)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  typedef struct {
    int due; int mode; int il; int er; int gc; int gs; string tag;
  } exp_t;
  exp_t sb[$];

  function automatic exp_t expect_of(logic [7:0] w, int due, string tag);
    exp_t e;
    e.due  = due;
    e.mode = w[7] ? 2 : (w[6] ? 0 : 1);
    e.il   = int'(w[5]);
    e.er   = int'(w[4]);
    e.gc   = int'(w[3:0]);
    e.gs   = 8 - int'(w[3:0]);
    e.tag  = tag;
    return e;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (sb.size() > 0 && cyc >= sb[0].due) begin
      exp_t e;
      e = sb.pop_front();
      chk(int'(mode_o) == e.mode, e.tag, "mode", int'(mode_o), e.mode);
      chk(int'(intlv_o) == e.il, e.tag, "intlv", int'(intlv_o), e.il);
      chk(int'(ext_ref_o) == e.er, e.tag, "ext_ref", int'(ext_ref_o), e.er);
      chk(int'(gain_code_o) == e.gc, e.tag, "gain_code", int'(gain_code_o), e.gc);
      chk(int'(gain_step_o) == e.gs, e.tag, "gain_step", int'(gain_step_o), e.gs);
    end
  end

  // wake-up tracking
  int t_normal = 0, t_ready = 0, ready_falls = 0;
  logic [1:0] prev_mode = 2'b00;
  logic prev_ready = 1'b1;
  always @(negedge clk) begin
    if (!rst) begin
      if (mode_o == 2'b00 && prev_mode != 2'b00) t_normal = cyc;
      if (ready_o && !prev_ready) t_ready = cyc;
      if (!ready_o && prev_ready) ready_falls++;
    end
    prev_mode  = mode_o;
    prev_ready = ready_o;
  end

  task automatic strobe(logic [7:0] w, logic [7:0] after);
    @(negedge clk);
    #1 cw_data = w; wr_n = 1'b0;
    #6 wr_n = 1'b1;
    #1 cw_data = after;
  endtask

  task automatic send(logic [7:0] w, logic [7:0] after, string tag);
    strobe(w, after);
    sb.push_back(expect_of(w, cyc + 6, tag));
    repeat (8) @(negedge clk);
  endtask

  task automatic wait_ready(int n, string tag);
    int k;
    k = 0;
    while (!ready_o && k < n + 50) begin
      @(negedge clk);
      k++;
    end
    @(negedge clk);
    chk(ready_o == 1'b1, tag, "ready", int'(ready_o), 1);
    chk((t_ready - t_normal) == n, tag, "wake cycles", t_ready - t_normal, n);
  endtask

  initial begin
    int falls0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2 reset values
    chk(mode_o == 2'b00, "R2", "mode", int'(mode_o), 0);
    chk(ready_o == 1'b1, "R2", "ready", int'(ready_o), 1);
    chk(intlv_o == 1'b0, "R2", "intlv", int'(intlv_o), 0);
    chk(ext_ref_o == 1'b0, "R2", "ext_ref", int'(ext_ref_o), 0);
    chk(gain_code_o == 4'b1000, "R2", "gain_code", int'(gain_code_o), 8);
    chk(gain_step_o == 5'sd0, "R2", "gain_step", int'(gain_step_o), 0);

    // R3 R6 R10: run-mode field writes, ready stays high
    falls0 = ready_falls;
    send(8'h70, 8'h70, "R3_R6_R10 code0000");
    chk(ready_o == 1'b1, "R10", "ready", int'(ready_o), 1);
    send(8'h4F, 8'h4F, "R3_R6 code1111");
    send(8'h58, 8'h58, "R3 ext_ref");
    chk(ready_falls == falls0, "R10", "ready falls", ready_falls, falls0);

    // R1: data changed after the strobe edge is ignored
    send(8'h43, 8'h2C, "R1 late data");
    repeat (4) @(negedge clk);
    chk(gain_code_o == 4'h3, "R1", "gain_code settled", int'(gain_code_o), 3);

    // R5 R7 R8: standby and return
    send(8'h0A, 8'h0A, "R5 standby");
    chk(ready_o == 1'b0, "R7", "ready in standby", int'(ready_o), 0);
    send(8'h48, 8'h48, "R5 run");
    wait_ready(STBY_N, "R8");

    // R4 R9: off mode with enable bit set, then return
    send(8'hC8, 8'hC8, "R4 off");
    chk(ready_o == 1'b0, "R7", "ready in off", int'(ready_o), 0);
    send(8'h48, 8'h48, "R9 run");
    wait_ready(PDN_N, "R9 direct");

    // R9: off -> standby -> run keeps the long delay
    send(8'h88, 8'h88, "R4 off2");
    send(8'h08, 8'h08, "R5 standby2");
    send(8'h48, 8'h48, "R9 run2");
    wait_ready(PDN_N, "R9 via standby");

    // R11: gain write during a standby wake-up
    send(8'h08, 8'h08, "R5 standby3");
    send(8'h48, 8'h48, "R11 run3");
    repeat (100) @(negedge clk);
    send(8'h45, 8'h45, "R11 gain during wake");
    chk(ready_o == 1'b0, "R11", "ready mid wake", int'(ready_o), 0);
    wait_ready(STBY_N, "R11");

    // R4: all bits set still powers down
    send(8'hFF, 8'hFF, "R4 all ones");
    chk(ready_o == 1'b0, "R4", "ready", int'(ready_o), 0);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule